// File: doc/BRIEF.md
# Selectable Tone Period Detector

This block decides whether a squared-up line signal carries a valid call-charge metering tone. Two tone rates are supported, 12 kHz and 16 kHz, and a select pin picks one of them. The block times each cycle of the digitised zero-crossing input by counting cycles of a 3.579545 MHz reference clock. It then checks the measured period against the accept window for the selected rate. A period counts as good only if the level detector reports enough amplitude for all of it.

Two outputs come from this verdict. The first is a one-cycle strobe with a good/bad flag for every judged period, which a cumulative qualifier further down the chain can use. The second is an active-low tone-follower output. It goes low once a short run of good periods has been seen, and it returns high on the first bad period.

Top module: `tone_period_det`

## Requirements
- R1: While reset is held and in the cycle after it is released, `tone_n` is 1 and `per_stb` is 0.
- R2: A period is the number of clock cycles between two rising edges of `zc_in`. With `sys_sel` = 1 (12 kHz), a period from 287 to 310 inclusive is good, and 286 or 311 is bad.
- R3: With `sys_sel` = 0 (16 kHz), a period from 215 to 233 inclusive is good, and 214, 234 or a 12 kHz period of 298 is bad.
- R4: `tone_n` goes to 0 only after three consecutive good periods. After two good periods it is still 1. It stays 0 while good periods continue.
- R5: A single bad period drives `tone_n` to 1 and restarts the run of good periods.
- R6: If `lvl_ok` is 0 in any cycle of a period, that period is bad.
- R7: If no rising edge arrives for 511 cycles after the last one, exactly one bad strobe is issued and `tone_n` goes to 1. The next rising edge only starts a new measurement and gives no strobe.
- R8: A change of `sys_sel` forces `tone_n` to 1 and clears the run of good periods. The period under way when the change happens is not judged, so the next edge gives no strobe.
- R9: The synchronised select resets to 12 kHz mode. An undriven select pin is pulled to 1 on the board, so the block locks to 12 kHz tones.
- R10: `per_stb` is a one-cycle pulse for each judged period, and `per_good` is valid in the same cycle. The first rising edge after reset gives no strobe.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | 3.579545 MHz reference clock |
| rst | input | 1 | Synchronous active-high reset |
| zc_in | input | 1 | Digitised zero-crossing signal, asynchronous |
| lvl_ok | input | 1 | Level detector flag, 1 when the amplitude is sufficient; synchronous to clk |
| sys_sel | input | 1 | Rate select: 1 = 12 kHz, 0 = 16 kHz |
| tone_n | output | 1 | Tone follower, 0 while a good tone is present |
| per_stb | output | 1 | One-cycle strobe at each judged period boundary |
| per_good | output | 1 | Verdict of the period, valid with per_stb |

## Verification
The assertions rely on two properties of the synchronised input. First, two detected rising edges are never adjacent. Second, `lvl_ok` and `sys_sel` change only between clock edges, so each is sampled cleanly. The stimulus meets both conditions: it changes every input on the falling clock edge, and it builds every zero-crossing waveform from half-periods at least a hundred cycles long. For the same reason, a select change is always made while the input is idle between periods, and the bench waits several cycles afterwards before sampling anything.

// File: rtl/tpd_pkg.sv
package tpd_pkg;

  // Default measurement geometry
  localparam int TPD_CNT_W       = 9;
  localparam int TPD_SYNC_STAGES = 2;
  localparam int TPD_GOOD_RUN    = 3;

  // Accept windows in reference-clock cycles
  localparam int TPD_W12_LO = 287;
  localparam int TPD_W12_HI = 310;
  localparam int TPD_W16_LO = 215;
  localparam int TPD_W16_HI = 233;

  // Verdict handed from the period meter to the follower
  typedef struct packed {
    logic stb;
    logic good;
  } tpd_verdict_t;

endpackage

// File: rtl/tpd_sync.sv
module tpd_sync #(
  parameter int STAGES  = 2,
  parameter bit RST_VAL = 1'b0
) (
  input  logic clk,
  input  logic rst,
  input  logic d,
  output logic q,
  output logic q_prev
);

  // chain[STAGES-1] is the synchronised value, chain[STAGES] its delayed copy
  logic [STAGES:0] chain;

  always_ff @(posedge clk) begin
    if (rst) chain <= {(STAGES+1){RST_VAL}};
    else     chain <= {chain[STAGES-1:0], d};
  end

  assign q      = chain[STAGES-1];
  assign q_prev = chain[STAGES];

endmodule

// File: rtl/tpd_window.sv
module tpd_window #(
  parameter int CNT_W  = 9,
  parameter int W12_LO = 287,
  parameter int W12_HI = 310,
  parameter int W16_LO = 215,
  parameter int W16_HI = 233
) (
  input  logic             sel12,
  input  logic [CNT_W-1:0] period,
  output logic             in_win
);

  // hit[0]: 16 kHz window, hit[1]: 12 kHz window
  logic [1:0] hit;

  for (genvar m = 0; m < 2; m++) begin : g_win
    localparam logic [CNT_W-1:0] LO_M = CNT_W'(m == 0 ? W16_LO : W12_LO);
    localparam logic [CNT_W-1:0] HI_M = CNT_W'(m == 0 ? W16_HI : W12_HI);
    assign hit[m] = (period >= LO_M) && (period <= HI_M);
  end

  assign in_win = hit[sel12];

endmodule

// File: rtl/tpd_period_meas.sv
module tpd_period_meas
  import tpd_pkg::*;
#(
  parameter int CNT_W = 9
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             rise,
  input  logic             lvl_ok,
  input  logic             restart,
  input  logic             in_win,
  output logic [CNT_W-1:0] cnt,
  output tpd_verdict_t     verdict
);

  localparam logic [CNT_W-1:0] SAT    = '1;
  localparam logic [CNT_W-1:0] SAT_M1 = SAT - 1'b1;
  localparam logic [CNT_W-1:0] ONE    = CNT_W'(1);

  logic [CNT_W-1:0] cnt_q;
  logic             armed_q;
  logic             lvl_low_q;
  tpd_verdict_t     verdict_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q     <= '0;
      armed_q   <= 1'b0;
      lvl_low_q <= 1'b0;
      verdict_q <= '0;
    end else begin
      verdict_q <= '0;
      if (rise) begin
        // close the running period and open the next one
        cnt_q     <= ONE;
        lvl_low_q <= !lvl_ok;
        armed_q   <= 1'b1;
        if (armed_q && !restart) begin
          verdict_q.stb  <= 1'b1;
          verdict_q.good <= in_win && !lvl_low_q && lvl_ok;
        end
      end else begin
        lvl_low_q <= lvl_low_q || !lvl_ok;
        if (cnt_q != SAT) begin
          cnt_q <= cnt_q + 1'b1;
          if (cnt_q == SAT_M1) begin
            // timed out: report once, then wait for a fresh edge
            armed_q <= 1'b0;
            if (armed_q && !restart) verdict_q.stb <= 1'b1;
          end
        end
        if (restart) armed_q <= 1'b0;
      end
    end
  end

  assign cnt     = cnt_q;
  assign verdict = verdict_q;

  // R10
  strobe_single_chk: assert property (@(posedge clk) disable iff (rst)
    verdict_q.stb |=> !verdict_q.stb);

  // R7
  sat_disarm_chk: assert property (@(posedge clk) disable iff (rst)
    (cnt_q == SAT) |-> !armed_q);

  // R6
  level_bad_chk: assert property (@(posedge clk) disable iff (rst)
    (rise && lvl_low_q) |=> !verdict_q.good);

endmodule

// File: rtl/tpd_follower.sv
module tpd_follower
  import tpd_pkg::*;
#(
  parameter int GOOD_RUN = 3
) (
  input  logic         clk,
  input  logic         rst,
  input  tpd_verdict_t verdict,
  input  logic         restart,
  output logic         tone_n
);

  localparam int RW = $clog2(GOOD_RUN + 1);
  localparam logic [RW-1:0] RUN_FULL = RW'(GOOD_RUN);

  logic [RW-1:0] run_q;
  logic [RW-1:0] run_nx;
  logic          tone_n_q;

  always_comb begin
    run_nx = run_q;
    if (run_q != RUN_FULL) run_nx = run_q + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      run_q    <= '0;
      tone_n_q <= 1'b1;
    end else if (restart) begin
      run_q    <= '0;
      tone_n_q <= 1'b1;
    end else if (verdict.stb) begin
      if (verdict.good) begin
        run_q    <= run_nx;
        tone_n_q <= (run_nx != RUN_FULL);
      end else begin
        run_q    <= '0;
        tone_n_q <= 1'b1;
      end
    end
  end

  assign tone_n = tone_n_q;

  // R5
  bad_release_chk: assert property (@(posedge clk) disable iff (rst)
    (verdict.stb && !verdict.good) |=> tone_n_q);

  // R4
  lock_cause_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(tone_n_q) |-> $past(verdict.stb && verdict.good));

  // R8
  sel_release_chk: assert property (@(posedge clk) disable iff (rst)
    restart |=> (tone_n_q && run_q == '0));

endmodule

// File: rtl/tone_period_det.sv
module tone_period_det
  import tpd_pkg::*;
#(
  parameter int CNT_W       = TPD_CNT_W,
  parameter int SYNC_STAGES = TPD_SYNC_STAGES,
  parameter int GOOD_RUN    = TPD_GOOD_RUN,
  parameter int W12_LO      = TPD_W12_LO,
  parameter int W12_HI      = TPD_W12_HI,
  parameter int W16_LO      = TPD_W16_LO,
  parameter int W16_HI      = TPD_W16_HI
) (
  input  logic clk,
  input  logic rst,
  input  logic zc_in,
  input  logic lvl_ok,
  input  logic sys_sel,
  output logic tone_n,
  output logic per_stb,
  output logic per_good
);

  logic             zc_q, zc_prev;
  logic             sel_q, sel_prev;
  logic             rise, sel_chg, in_win;
  logic [CNT_W-1:0] cnt;
  tpd_verdict_t     verdict;

  tpd_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_zc_sync (
    .clk(clk), .rst(rst), .d(zc_in), .q(zc_q), .q_prev(zc_prev)
  );

  // select resets to 12 kHz
  tpd_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sel_sync (
    .clk(clk), .rst(rst), .d(sys_sel), .q(sel_q), .q_prev(sel_prev)
  );

  assign rise    = zc_q && !zc_prev;
  assign sel_chg = sel_q ^ sel_prev;

  tpd_window #(
    .CNT_W(CNT_W), .W12_LO(W12_LO), .W12_HI(W12_HI),
    .W16_LO(W16_LO), .W16_HI(W16_HI)
  ) u_window (
    .sel12(sel_q), .period(cnt), .in_win(in_win)
  );

  tpd_period_meas #(.CNT_W(CNT_W)) u_meas (
    .clk(clk), .rst(rst), .rise(rise), .lvl_ok(lvl_ok),
    .restart(sel_chg), .in_win(in_win), .cnt(cnt), .verdict(verdict)
  );

  tpd_follower #(.GOOD_RUN(GOOD_RUN)) u_follow (
    .clk(clk), .rst(rst), .verdict(verdict), .restart(sel_chg),
    .tone_n(tone_n)
  );

  assign per_stb  = verdict.stb;
  assign per_good = verdict.good;

  // R1
  reset_idle_chk: assert property (@(posedge clk)
    $past(rst) |-> (tone_n && !per_stb));

endmodule

// File: tb/tone_period_det_tb.sv
`timescale 1ns/1ps
module tone_period_det_tb;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic rst = 1'b1;
  logic zc = 1'b0;
  logic lvl = 1'b1;
  logic sel_en = 1'b0;
  logic sel_val = 1'b1;
  wire  sys_sel = sel_en ? sel_val : 1'b1;  // board pull-up model
  logic tone_n, per_stb, per_good;

  int checks = 0, errors = 0, stb_total = 0;
  logic last_good = 1'b0;
  bit done = 1'b0;

  tone_period_det u_dut (
    .clk(clk), .rst(rst), .zc_in(zc), .lvl_ok(lvl), .sys_sel(sys_sel),
    .tone_n(tone_n), .per_stb(per_stb), .per_good(per_good)
  );

  always @(posedge clk) begin
    #1;
    if (!rst && per_stb) begin
      stb_total++;
      last_good = per_good;
    end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic drive_period(input int p);
    zc = 1'b1;
    repeat (p / 2) @(negedge clk);
    zc = 1'b0;
    repeat (p - p / 2) @(negedge clk);
  endtask

  task automatic lock(input int p);
    for (int i = 0; i < 4; i++) drive_period(p);
  endtask

  task automatic judge(input int p, input int nom, input bit exp, input string req);
    drive_period(p);
    drive_period(nom);
    chk(last_good == exp, req, $sformatf("verdict for period %0d", p),
        int'(last_good), int'(exp));
  endtask

  task automatic t_reset;
    rst = 1'b1;
    repeat (5) @(negedge clk);
    chk(tone_n == 1'b1, "R1", "tone_n in reset", tone_n, 1);
    rst = 1'b0;
    @(negedge clk);
    chk(tone_n == 1'b1, "R1", "tone_n after reset", tone_n, 1);
    chk(per_stb == 1'b0, "R1", "per_stb after reset", per_stb, 0);
  endtask

  task automatic t_lock12;
    int s0;
    s0 = stb_total;
    drive_period(298);
    chk(stb_total == s0, "R10", "strobes after first edge", stb_total - s0, 0);
    drive_period(298);
    drive_period(298);
    chk(stb_total - s0 == 2, "R10", "strobe count", stb_total - s0, 2);
    chk(last_good == 1'b1, "R2", "298 good", last_good, 1);
    chk(tone_n == 1'b1, "R4", "tone_n after two good", tone_n, 1);
    drive_period(298);
    chk(tone_n == 1'b0, "R4", "tone_n after three good", tone_n, 0);
    chk(tone_n == 1'b0, "R9", "undriven select locks 12 kHz", tone_n, 0);
    drive_period(300);
    chk(tone_n == 1'b0, "R4", "tone_n stays low", tone_n, 0);
  endtask

  task automatic t_win12;
    judge(286, 298, 1'b0, "R2");
    judge(287, 298, 1'b1, "R2");
    judge(310, 298, 1'b1, "R2");
    judge(311, 298, 1'b0, "R2");
  endtask

  task automatic t_bad;
    lock(298);
    chk(tone_n == 1'b0, "R5", "locked before bad period", tone_n, 0);
    drive_period(250);
    drive_period(298);
    chk(tone_n == 1'b1, "R5", "tone_n after one bad", tone_n, 1);
    drive_period(298);
    drive_period(298);
    chk(tone_n == 1'b1, "R5", "run restarted after bad", tone_n, 1);
  endtask

  task automatic t_level;
    lock(298);
    lvl = 1'b0;
    drive_period(298);
    lvl = 1'b1;
    drive_period(298);
    chk(last_good == 1'b0, "R6", "low level period verdict", last_good, 0);
    chk(tone_n == 1'b1, "R6", "tone_n after low level", tone_n, 1);
  endtask

  task automatic t_sat;
    int s;
    lock(298);
    drive_period(298);
    s = stb_total;
    repeat (600) @(negedge clk);
    chk(stb_total - s == 1, "R7", "timeout strobes", stb_total - s, 1);
    chk(last_good == 1'b0, "R7", "timeout verdict", last_good, 0);
    chk(tone_n == 1'b1, "R7", "tone_n after timeout", tone_n, 1);
    s = stb_total;
    drive_period(298);
    chk(stb_total == s, "R7", "no strobe on re-arm", stb_total - s, 0);
  endtask

  task automatic t_sel16;
    int s;
    lock(298);
    chk(tone_n == 1'b0, "R8", "locked before select change", tone_n, 0);
    sel_en = 1'b1;
    sel_val = 1'b0;
    repeat (10) @(negedge clk);
    chk(tone_n == 1'b1, "R8", "tone_n after select change", tone_n, 1);
    s = stb_total;
    drive_period(224);
    chk(stb_total == s, "R8", "running period not judged", stb_total - s, 0);
    drive_period(224);
    drive_period(224);
    chk(tone_n == 1'b1, "R3", "16 kHz two good", tone_n, 1);
    drive_period(224);
    chk(tone_n == 0, "R3", "16 kHz lock", tone_n, 0);
    judge(214, 224, 1'b0, "R3");
    judge(215, 224, 1'b1, "R3");
    judge(233, 224, 1'b1, "R3");
    judge(234, 224, 1'b0, "R3");
    judge(298, 224, 1'b0, "R3");
  endtask

  initial begin
    t_reset;
    t_lock12;
    t_win12;
    t_bad;
    t_level;
    t_sat;
    t_sel16;
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(5.0 * 150000);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule